// File: doc/BRIEF.md
# Branch Record Type and Privilege Filter

This block sits between instruction retirement and a branch record buffer. For every retired branch it decides whether the branch is kept. If it is, the block also decides what form the record takes. A branch arrives as a descriptor: class, source and target exception level, source and target address, mispredict flag and cycle count. Two control words shape the decision. One holds a six-bit type filter for ordinary branches. The other holds the privilege, exception-class and field-capture enables.

Ordinary branches are kept only when their class is enabled and both ends run at an enabled level. Exception entries and exception returns use their own enables. They are kept when at least one end is at an enabled level. The address on the disallowed end is zeroed, and the record is tagged as source-only or target-only. The decision is registered, and the write strobe with the record follows one cycle after the branch is presented.

Top module: `branch_rec_filter`

## Requirements
- R1: A write strobe `rec_wr` is asserted exactly one clock after an accepted `br_valid` cycle. It lasts one cycle, and it is never asserted in a cycle that follows a clock with `br_valid` low.
- R2: Ordinary classes use these `br_class` codes and `type_en` bits: 0 direct unconditional (bit 0), 1 indirect jump (bit 1), 2 return (bit 2), 3 indirect call (bit 3), 4 direct call (bit 4), 5 conditional direct (bit 5). An ordinary branch is recorded only when its own bit is set.
- R3: `ctrl[0]` enables level 0 (user) and `ctrl[1]` enables level 1 (kernel). Level 2 is never an enabled level. With both bits clear, no branch of any class is recorded.
- R4: An ordinary branch is recorded only when both its source and target levels are enabled. Its validity code is then 2'b11 (full).
- R5: Exception entries (codes 8 trap, 9 IRQ, 10 FIQ, 11 SError, 12 alignment fault, 13 instruction fault, 14 data fault, 15 debug halt, 16 debug exit) are gated by `ctrl[2]`. Exception return (code 6) is gated by `ctrl[3]`. Neither is affected by `type_en`.
- R6: For an exception-class record, a disallowed source gives `rec_src` = 0 with validity 2'b01 (target-only). A disallowed target gives `rec_tgt` = 0 with validity 2'b10 (source-only). Both ends allowed give 2'b11.
- R7: When neither end of a branch is at an enabled level, no strobe is issued, and this includes exception-class branches.
- R8: Info bits [CYC_W+7:8] carry `br_cycles` when `ctrl[4]` is set, and read zero otherwise.
- R9: Info bit 7 carries `br_mispred` when `ctrl[5]` is set and the record is not target-only. Otherwise it is zero.
- R10: Info bits [4:0] carry the class code. Codes 7 and 17 to 31 are never recorded.
- R11: Info bits [6:5] carry the record's level as the target level (0 = EL0, 1 = EL1, 2 = EL2). A source-only record reads 0 there.
- R12: While reset is asserted, `rec_wr` is low and every record output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A retired branch is presented this cycle |
| br_class | input | 5 | Branch class code |
| br_src_el | input | 2 | Exception level at the source |
| br_tgt_el | input | 2 | Exception level at the target |
| br_src_addr | input | AW | Source address |
| br_tgt_addr | input | AW | Target address |
| br_mispred | input | 1 | Branch was mispredicted |
| br_cycles | input | CYC_W | Cycles since the previous record |
| type_en | input | 6 | Ordinary class enables |
| ctrl | input | 6 | Level, exception-class and field enables |
| rec_wr | output | 1 | Record write strobe |
| rec_src | output | AW | Recorded source address |
| rec_tgt | output | AW | Recorded target address |
| rec_info | output | CYC_W+8 | Info word: type, level, mispredict, cycles |
| rec_vld | output | 2 | Validity: 11 full, 10 source-only, 01 target-only |

## Verification
Each of the six ordinary classes is sent against each one-hot type filter. This shows whether class decoding is crossed between filter bits. Ordinary branches at user, kernel and level 2, and branches that cross levels, separate the both-ends rule from the either-end rule used for exceptions. IRQ entries and exception returns are sent with one end's level disabled in turn. This shows which end is zeroed and how the validity, level and mispredict fields follow. Unknown class codes, cleared enables and the field-capture switches confirm that nothing leaks into the record when it should not.

// File: rtl/branch_rec_filter.sv
module branch_rec_filter #(
  parameter int AW    = 48,
  parameter int CYC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [4:0]        br_class,
  input  logic [1:0]        br_src_el,
  input  logic [1:0]        br_tgt_el,
  input  logic [AW-1:0]     br_src_addr,
  input  logic [AW-1:0]     br_tgt_addr,
  input  logic              br_mispred,
  input  logic [CYC_W-1:0]  br_cycles,
  input  logic [5:0]        type_en,
  input  logic [5:0]        ctrl,
  output logic              rec_wr,
  output logic [AW-1:0]     rec_src,
  output logic [AW-1:0]     rec_tgt,
  output logic [CYC_W+7:0]  rec_info,
  output logic [1:0]        rec_vld
);
  localparam int INFO_W = CYC_W + 8;
  localparam logic [4:0] C_ERET = 5'd6;
  localparam logic [4:0] C_EXC_LO = 5'd8;
  localparam logic [4:0] C_EXC_HI = 5'd16;
  localparam logic [1:0] V_TGT = 2'b01;
  localparam logic [1:0] V_SRC = 2'b10;

  logic is_ord, is_eret, is_exc, src_ok, tgt_ok, class_on, accept;
  logic [1:0] vld_n;
  logic [1:0] el_n;
  logic [INFO_W-1:0] info_n;

  assign is_ord  = br_class < C_ERET;
  assign is_eret = br_class == C_ERET;
  assign is_exc  = (br_class >= C_EXC_LO) && (br_class <= C_EXC_HI);

  assign src_ok = (br_src_el == 2'd0 && ctrl[0]) || (br_src_el == 2'd1 && ctrl[1]);
  assign tgt_ok = (br_tgt_el == 2'd0 && ctrl[0]) || (br_tgt_el == 2'd1 && ctrl[1]);

  always_comb begin
    if (is_ord)       class_on = type_en[br_class[2:0]];
    else if (is_eret) class_on = ctrl[3];
    else if (is_exc)  class_on = ctrl[2];
    else              class_on = 1'b0;
  end

  assign accept = br_valid && class_on &&
                  (is_ord ? (src_ok && tgt_ok) : (src_ok || tgt_ok));

  assign vld_n = {src_ok, tgt_ok};
  assign el_n  = (vld_n == V_SRC) ? 2'd0 : br_tgt_el;

  assign info_n = {ctrl[4] ? br_cycles : {CYC_W{1'b0}},
                   ctrl[5] && (vld_n != V_TGT) && br_mispred,
                   el_n,
                   br_class};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_wr   <= 1'b0;
      rec_src  <= '0;
      rec_tgt  <= '0;
      rec_info <= '0;
      rec_vld  <= '0;
    end else begin
      rec_wr <= accept;
      if (accept) begin
        rec_src  <= src_ok ? br_src_addr : '0;
        rec_tgt  <= tgt_ok ? br_tgt_addr : '0;
        rec_info <= info_n;
        rec_vld  <= vld_n;
      end
    end
  end
endmodule

// File: rtl/branch_rec_filter_chk.sv
module branch_rec_filter_chk #(
  parameter int AW    = 48,
  parameter int CYC_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [1:0]        br_src_el,
  input logic [1:0]        br_tgt_el,
  input logic [5:0]        ctrl,
  input logic              rec_wr,
  input logic [AW-1:0]     rec_src,
  input logic [AW-1:0]     rec_tgt,
  input logic [CYC_W+7:0]  rec_info,
  input logic [1:0]        rec_vld
);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !rec_wr);
  a_r3_levels_off: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !ctrl[0] && !ctrl[1] |=> !rec_wr);
  a_r7_both_el2: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_src_el == 2'd2 && br_tgt_el == 2'd2 |=> !rec_wr);
  a_r6_code_set: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr |-> rec_vld != 2'b00);
  a_r6_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr && rec_vld == 2'b01 |-> rec_src == '0);
  a_r6_tgt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr && rec_vld == 2'b10 |-> rec_tgt == '0);
  a_r8_cyc_off: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !ctrl[4] |=> !rec_wr || rec_info[CYC_W+7:8] == '0);
  a_r9_tonly_mp: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr && rec_vld == 2'b01 |-> !rec_info[7]);
  a_r11_sonly_el: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr && rec_vld == 2'b10 |-> rec_info[6:5] == 2'd0);
  a_r4_ord_full: assert property (@(posedge clk) disable iff (!rst_n)
    rec_wr && rec_info[4:0] < 5'd6 |-> rec_vld == 2'b11);
endmodule

bind branch_rec_filter branch_rec_filter_chk #(.AW(AW), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src_el(br_src_el),
  .br_tgt_el(br_tgt_el), .ctrl(ctrl), .rec_wr(rec_wr), .rec_src(rec_src),
  .rec_tgt(rec_tgt), .rec_info(rec_info), .rec_vld(rec_vld)
);

// File: tb/sim_branch_rec_filter.sv
`timescale 1ns/1ps
module sim_branch_rec_filter;
  localparam int AW = 48;
  localparam int CYC_W = 16;
  localparam logic [AW-1:0] SRC = 48'h1111_0000_0A00;
  localparam logic [AW-1:0] TGT = 48'h2222_0000_0B00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 1'b0;
  logic [4:0] br_class = '0;
  logic [1:0] br_src_el = '0, br_tgt_el = '0;
  logic [AW-1:0] br_src_addr = SRC, br_tgt_addr = TGT;
  logic br_mispred = 1'b0;
  logic [CYC_W-1:0] br_cycles = '0;
  logic [5:0] type_en = '0, ctrl = '0;
  logic rec_wr;
  logic [AW-1:0] rec_src, rec_tgt;
  logic [CYC_W+7:0] rec_info;
  logic [1:0] rec_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  branch_rec_filter #(.AW(AW), .CYC_W(CYC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_class(br_class),
    .br_src_el(br_src_el), .br_tgt_el(br_tgt_el), .br_src_addr(br_src_addr),
    .br_tgt_addr(br_tgt_addr), .br_mispred(br_mispred), .br_cycles(br_cycles),
    .type_en(type_en), .ctrl(ctrl), .rec_wr(rec_wr), .rec_src(rec_src),
    .rec_tgt(rec_tgt), .rec_info(rec_info), .rec_vld(rec_vld)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic send(input logic [4:0] cls, input logic [1:0] sel, input logic [1:0] tel,
                      input logic mp, input logic [CYC_W-1:0] cyc);
    @(negedge clk);
    br_valid = 1'b1; br_class = cls; br_src_el = sel; br_tgt_el = tel;
    br_mispred = mp; br_cycles = cyc;
    @(posedge clk);
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    br_valid = 1'b1; ctrl = 6'h3F; type_en = 6'h3F;
    repeat (3) @(negedge clk);
    chk("R12 wr", rec_wr, 0);
    chk("R12 vld", rec_vld, 0);
    chk("R12 info", rec_info, 0);
    chk("R12 src", rec_src, 0);
    br_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_types;
    ctrl = 6'b000011;
    for (int f = 0; f < 6; f++) begin
      type_en = 6'b1 << f;
      for (int c = 0; c < 6; c++) begin
        send(5'(c), 2'd1, 2'd1, 1'b0, '0);
        chk("R2 class filter", rec_wr, (c == f));
        if (c == f) begin
          chk("R10 type field", rec_info[4:0], c);
          chk("R4 full code", rec_vld, 2'b11);
        end
      end
    end
  endtask

  task automatic t_priv;
    type_en = 6'h3F;
    ctrl = 6'b000010;
    send(5'd4, 2'd0, 2'd0, 1'b0, '0);
    chk("R3 user disabled", rec_wr, 0);
    ctrl = 6'b000001;
    send(5'd4, 2'd0, 2'd0, 1'b0, '0);
    chk("R3 user enabled", rec_wr, 1);
    chk("R11 el0 field", rec_info[6:5], 0);
    send(5'd4, 2'd0, 2'd1, 1'b0, '0);
    chk("R4 crossing ordinary", rec_wr, 0);
    ctrl = 6'b000011;
    send(5'd1, 2'd2, 2'd2, 1'b0, '0);
    chk("R3 el2 never", rec_wr, 0);
    ctrl = 6'b111100;
    send(5'd9, 2'd0, 2'd1, 1'b0, '0);
    chk("R3 both levels off", rec_wr, 0);
  endtask

  task automatic t_exc;
    type_en = 6'h00;
    ctrl = 6'b100101;
    send(5'd9, 2'd0, 2'd1, 1'b1, '0);
    chk("R6 src-only wr", rec_wr, 1);
    chk("R6 src-only code", rec_vld, 2'b10);
    chk("R6 src kept", rec_src, SRC);
    chk("R6 tgt zeroed", rec_tgt, 0);
    chk("R11 src-only el", rec_info[6:5], 0);
    chk("R9 src-only mp", rec_info[7], 1);
    ctrl = 6'b100110;
    send(5'd9, 2'd0, 2'd1, 1'b1, '0);
    chk("R6 tgt-only code", rec_vld, 2'b01);
    chk("R6 src zeroed", rec_src, 0);
    chk("R6 tgt kept", rec_tgt, TGT);
    chk("R11 tgt-only el", rec_info[6:5], 1);
    chk("R9 tgt-only mp", rec_info[7], 0);
    chk("R10 irq code", rec_info[4:0], 9);
    ctrl = 6'b100011;
    send(5'd9, 2'd0, 2'd1, 1'b0, '0);
    chk("R5 exc disabled", rec_wr, 0);
    ctrl = 6'b001011;
    send(5'd6, 2'd1, 2'd0, 1'b0, '0);
    chk("R5 eret enabled", rec_wr, 1);
    chk("R5 eret full", rec_vld, 2'b11);
    chk("R10 eret code", rec_info[4:0], 6);
    ctrl = 6'b000111;
    send(5'd6, 2'd1, 2'd0, 1'b0, '0);
    chk("R5 eret disabled", rec_wr, 0);
    ctrl = 6'b001110;
    send(5'd6, 2'd2, 2'd0, 1'b0, '0);
    chk("R7 neither side eret", rec_wr, 0);
    ctrl = 6'b000111;
    send(5'd16, 2'd2, 2'd2, 1'b0, '0);
    chk("R7 neither side exc", rec_wr, 0);
    send(5'd16, 2'd2, 2'd1, 1'b0, '0);
    chk("R5 debug exit", rec_wr, 1);
  endtask

  task automatic t_fields;
    type_en = 6'h3F;
    ctrl = 6'b110011;
    send(5'd3, 2'd1, 2'd1, 1'b1, 16'hBEEF);
    chk("R8 cycles on", rec_info[CYC_W+7:8], 16'hBEEF);
    chk("R9 mispred on", rec_info[7], 1);
    chk("R11 el1 field", rec_info[6:5], 1);
    ctrl = 6'b000011;
    send(5'd3, 2'd1, 2'd1, 1'b1, 16'hBEEF);
    chk("R8 cycles off", rec_info[CYC_W+7:8], 0);
    chk("R9 mispred off", rec_info[7], 0);
    ctrl = 6'b111111;
    send(5'd7, 2'd1, 2'd1, 1'b0, '0);
    chk("R10 code 7 dropped", rec_wr, 0);
    send(5'd20, 2'd1, 2'd1, 1'b0, '0);
    chk("R10 code 20 dropped", rec_wr, 0);
  endtask

  task automatic t_latency;
    type_en = 6'h3F; ctrl = 6'b000011;
    @(negedge clk);
    br_valid = 1'b1; br_class = 5'd0; br_src_el = 2'd1; br_tgt_el = 2'd1;
    #1;
    chk("R1 not same cycle", rec_wr, 0);
    @(negedge clk);
    br_valid = 1'b0;
    chk("R1 one cycle later", rec_wr, 1);
    @(negedge clk);
    chk("R1 single pulse", rec_wr, 0);
  endtask

  initial begin
    t_reset();
    t_types();
    t_priv();
    t_exc();
    t_fields();
    t_latency();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule